// File: doc/BRIEF.md
# Keyed-Restart Watchdog Timer

This block is a watchdog counter that is reached through a small 8-bit register interface. Software writes a mode register once after reset to pick what happens on expiry and how long the timeout is. It then keeps the watchdog alive by writing a single restart key. The count advances on a slow-clock enable pulse. The enable is synchronous to the system clock.

On expiry the block does one of two things, depending on the mode. It either raises a one-cycle non-maskable interrupt request, or it drives an internal reset pulse of fixed length that goes to the reset controller. Some accesses are treated as evidence of runaway software and make the watchdog expire at once: a wrong restart key, or any further write to the already-locked mode register. These forced expiries are suppressed while the counter is halted.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the mode register reads 0x67, both outputs are low, and the counter runs in reset mode with exponent BASE_EXP+7. The first expiry therefore comes after 2^(BASE_EXP+7) slow ticks.
- R2: The mode register (address 0) accepts only the first write after reset. Bit 7 is stored as 0. Every later write leaves the stored value unchanged.
- R3: While the counter runs, a second or later mode register write forces an expiry in that same cycle.
- R4: Writing 0xAC to the key register (address 1) clears the counter to zero. With a tick on every cycle, expiry is then seen 2^N+1 clocks after the write cycle.
- R5: While the counter runs, a key write of any value other than 0xAC forces an expiry, which is visible on the outputs in the next cycle.
- R6: With mode bits [6:5] = 00 the counter is halted and no expiry is produced by any means: not by wrong keys, not by repeated mode writes, not by ticks.
- R7: The expiry exponent is N = BASE_EXP + bits[2:0] of the mode register, and bits [4:3] have no effect. With the default BASE_EXP of 9, the value 0x5B gives reset mode with a period of 2^12 ticks.
- R8: Mode bits [6:5] = 01 turn an expiry into a one-cycle nmi_req strobe. Bits [6:5] = 1x turn it into a wdt_rst pulse of RST_LEN clocks, starting the cycle after the expiry.
- R9: Reading the key register always returns 0x9A.
- R10: The counter advances only in cycles where slow_tick is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | One-cycle enable per slow-clock period |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select: 0 mode, 1 key |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register (combinational) |
| nmi_req | output | 1 | One-cycle interrupt request on expiry |
| wdt_rst | output | 1 | Internal reset pulse on expiry |

## Verification
The assertions take for granted that slow_tick, bus_we, bus_addr and bus_wdata are synchronous to clk and hold steady around each rising edge. They also assume that a write lasts exactly one cycle, so that a single strobe is never counted as two mode writes. The stimulus changes every input only on the falling edge. Each write task raises bus_we for exactly one cycle. The tick source is either always high, always low, or high every third cycle. A fresh reset is applied before each new mode is programmed.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

  localparam logic       ADDR_MODE    = 1'b0;
  localparam logic       ADDR_KEY     = 1'b1;
  localparam logic [7:0] KEY_RESTART  = 8'hAC;
  localparam logic [7:0] KEY_READBACK = 8'h9A;
  localparam logic [7:0] MODE_RESET   = 8'h67;

  typedef enum logic [1:0] {
    OP_HALT   = 2'b00,
    OP_NMI    = 2'b01,
    OP_RESETA = 2'b10,
    OP_RESETB = 2'b11
  } op_mode_e;

  function automatic op_mode_e mode_op(input logic [7:0] m);
    return op_mode_e'(m[6:5]);
  endfunction

  function automatic logic mode_running(input logic [7:0] m);
    return mode_op(m) != OP_HALT;
  endfunction

  function automatic logic mode_resets(input logic [7:0] m);
    return m[6];
  endfunction

  function automatic logic mode_interrupts(input logic [7:0] m);
    return mode_op(m) == OP_NMI;
  endfunction

  // Right shift applied to an all-ones counter word to obtain 2^N-1,
  // where N = base + sel and the word is base+7 bits wide.
  function automatic logic [2:0] span_shift(input logic [2:0] sel);
    return 3'd7 - sel;
  endfunction

endpackage

// File: rtl/kwdt_regs.sv
module kwdt_regs
  import kwdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic       addr,
  input  logic [7:0] wdata,
  output logic [7:0] mode_q,
  output logic [7:0] rdata,
  output logic       clear_o,
  output logic       force_o
);

  logic locked_q;
  logic mode_wr;
  logic key_wr;
  logic key_good;
  logic running;

  assign mode_wr  = we && (addr == ADDR_MODE);
  assign key_wr   = we && (addr == ADDR_KEY);
  assign key_good = (wdata == KEY_RESTART);
  assign running  = mode_running(mode_q);

  assign clear_o = (mode_wr && !locked_q) || (key_wr && key_good);
  assign force_o = running && ((mode_wr && locked_q) || (key_wr && !key_good));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MODE_RESET;
      locked_q <= 1'b0;
    end else if (mode_wr && !locked_q) begin
      mode_q   <= {1'b0, wdata[6:0]};
      locked_q <= 1'b1;
    end
  end

  assign rdata = (addr == ADDR_KEY) ? KEY_READBACK : mode_q;

  assert_mode_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> (locked_q && $stable(mode_q)));

  assert_top_bit_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> !mode_q[7]);

endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter
  import kwdt_pkg::*;
#(
  parameter int BASE_EXP = 9,
  localparam int CNT_W = BASE_EXP + 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       run,
  input  logic [2:0] sel,
  input  logic       clear_i,
  input  logic       force_i,
  output logic       wrap_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  assign limit  = {CNT_W{1'b1}} >> span_shift(sel);
  assign wrap_o = run && tick && !clear_i && (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (clear_i || force_i || wrap_o)
      cnt_q <= '0;
    else if (run && tick)
      cnt_q <= cnt_q + 1'b1;
  end

  assert_clear_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (cnt_q == '0));

  assert_hold_without_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clear_i && !force_i) |=> $stable(cnt_q));

  assert_count_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q <= limit) || $past(clear_i));

endmodule

// File: rtl/kwdt_out.sv
module kwdt_out #(
  parameter int RST_LEN = 4,
  localparam int RC_W = $clog2(RST_LEN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ovf_i,
  input  logic rst_mode_i,
  input  logic nmi_mode_i,
  output logic nmi_req,
  output logic wdt_rst
);

  logic [RC_W-1:0] rc_q;
  logic            nmi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rc_q  <= '0;
      nmi_q <= 1'b0;
    end else begin
      nmi_q <= ovf_i && nmi_mode_i;
      if (ovf_i && rst_mode_i)
        rc_q <= RC_W'(RST_LEN);
      else if (rc_q != '0)
        rc_q <= rc_q - 1'b1;
    end
  end

  assign nmi_req = nmi_q;
  assign wdt_rst = (rc_q != '0);

  assert_rst_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_i && rst_mode_i) |=> wdt_rst);

  assert_nmi_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_i && nmi_mode_i) |=> nmi_req);

  assert_nmi_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf_i |=> !nmi_req);

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import kwdt_pkg::*;
#(
  parameter int BASE_EXP = 9,
  parameter int RST_LEN  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       slow_tick,
  input  logic       bus_we,
  input  logic       bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       nmi_req,
  output logic       wdt_rst
);

  logic [7:0] mode_q;
  logic       clear_evt;
  logic       force_evt;
  logic       wrap_evt;
  logic       ovf_evt;
  logic       run;

  kwdt_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (bus_we),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .mode_q  (mode_q),
    .rdata   (bus_rdata),
    .clear_o (clear_evt),
    .force_o (force_evt)
  );

  assign run = mode_running(mode_q);

  kwdt_counter #(.BASE_EXP(BASE_EXP)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (slow_tick),
    .run     (run),
    .sel     (mode_q[2:0]),
    .clear_i (clear_evt),
    .force_i (force_evt),
    .wrap_o  (wrap_evt)
  );

  assign ovf_evt = force_evt || wrap_evt;

  kwdt_out #(.RST_LEN(RST_LEN)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .ovf_i      (ovf_evt),
    .rst_mode_i (mode_resets(mode_q)),
    .nmi_mode_i (mode_interrupts(mode_q)),
    .nmi_req    (nmi_req),
    .wdt_rst    (wdt_rst)
  );

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !ovf_evt);

  assert_wrong_key_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr && (bus_wdata != KEY_RESTART) && run) |-> ovf_evt);

  assert_locked_rewrite_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !bus_addr && run && $past(bus_we && !bus_addr)) |-> ovf_evt);

endmodule

// File: tb/sim_keyed_watchdog.sv
module sim_keyed_watchdog;

  localparam int BASE = 4;
  localparam int RLEN = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       slow_tick = 1'b0;
  logic       bus_we = 1'b0;
  logic       bus_addr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       nmi_req;
  logic       wdt_rst;

  int checks = 0;
  int errors = 0;
  int tick_kind = 1;
  int cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  keyed_watchdog #(.BASE_EXP(BASE), .RST_LEN(RLEN)) u0 (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .nmi_req(nmi_req), .wdt_rst(wdt_rst)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // tick generator: 0 never, 1 every cycle, 2 every third cycle
  always @(negedge clk) begin
    cyc++;
    case (tick_kind)
      0: slow_tick = 1'b0;
      1: slow_tick = 1'b1;
      default: slow_tick = (cyc % 3 == 0);
    endcase
  end

  // behavioural reference, compared on every clock
  int m_mode, m_lock, m_cnt, m_rc, m_nmi;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 'h67; m_lock = 0; m_cnt = 0; m_rc = 0; m_nmi = 0;
    end else begin
      int run, n, lim, newmode, ovf, clr;
      run = ((m_mode >> 5) & 3) != 0;
      n = BASE + (m_mode & 7);
      lim = (1 << n) - 1;
      newmode = m_mode; ovf = 0; clr = 0;
      if (bus_we && bus_addr == 0) begin
        if (!m_lock) begin newmode = bus_wdata & 'h7F; m_lock = 1; clr = 1; end
        else if (run) ovf = 1;
      end
      if (bus_we && bus_addr == 1) begin
        if (bus_wdata == 8'hAC) clr = 1;
        else if (run) ovf = 1;
      end
      if (!clr && run && slow_tick && m_cnt == lim) ovf = 1;
      if (clr || ovf) m_cnt = 0;
      else if (run && slow_tick) m_cnt++;
      m_nmi = ovf && (((m_mode >> 5) & 3) == 1);
      if (ovf && ((m_mode >> 6) & 1)) m_rc = RLEN;
      else if (m_rc > 0) m_rc--;
      m_mode = newmode;
    end
    #3;
    if (rst_n) begin
      chk("R8 R10 model nmi_req", nmi_req, m_nmi);
      chk("R8 R10 model wdt_rst", wdt_rst, m_rc > 0);
      chk("R2 R9 model rdata", bus_rdata, bus_addr ? 8'h9A : m_mode[7:0]);
    end
  end

  task automatic wr(input logic a, input logic [7:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: bench hung");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    @(negedge clk);
    do_reset();
    // R1 reset state
    bus_addr = 1'b0;
    #1 chk("R1 mode after reset", bus_rdata, 8'h67);
    chk("R1 nmi low", nmi_req, 0);
    chk("R1 rst low", wdt_rst, 0);
    bus_addr = 1'b1;
    #1 chk("R9 key readback", bus_rdata, 8'h9A);
    // R1 default period in reset mode: exponent BASE+7
    n = 0;
    while (!wdt_rst && n < 5000) begin @(negedge clk); n++; end
    chk("R1 default expiry delay", n, 1 << (BASE + 7));
    // R8 pulse length
    n = 0;
    while (wdt_rst && n < 100) begin @(negedge clk); n++; end
    chk("R8 reset pulse length", n, RLEN);

    // R5 wrong key in default reset mode
    do_reset();
    idle(2);
    wr(1'b1, 8'h55);
    chk("R5 wrong key forces reset", wdt_rst, 1);
    idle(8);

    // R2 first write locks, bit 7 dropped; R3 second write forces expiry
    wr(1'b0, 8'hDB);
    bus_addr = 1'b0;
    #1 chk("R2 first write stored, bit7 zero", bus_rdata, 8'h5B);
    idle(8);
    wr(1'b0, 8'h00);
    chk("R3 second mode write forces reset", wdt_rst, 1);
    bus_addr = 1'b0;
    #1 chk("R2 second write ignored", bus_rdata, 8'h5B);
    idle(8);
    // R4 R7 period after restart key: N = BASE+3
    wr(1'b1, 8'hAC);
    n = 1;
    while (!wdt_rst && n < 5000) begin @(negedge clk); n++; end
    chk("R4 R7 expiry after restart key", n, (1 << (BASE + 3)) + 1);
    bus_addr = 1'b1;
    #1 chk("R9 key reads 9A after writes", bus_rdata, 8'h9A);
    idle(8);

    // R8 interrupt mode with bits[4:3] set (R7 ignores them)
    do_reset();
    wr(1'b0, 8'h39);
    wr(1'b1, 8'hAC);
    n = 1;
    while (!nmi_req && n < 5000) begin @(negedge clk); n++; end
    chk("R7 R8 nmi expiry, bits4:3 ignored", n, (1 << (BASE + 1)) + 1);
    @(negedge clk);
    chk("R8 nmi is one cycle", nmi_req, 0);
    chk("R8 no reset in nmi mode", wdt_rst, 0);
    wr(1'b1, 8'h00);
    chk("R5 wrong key raises nmi", nmi_req, 1);
    // R10 sparse and absent ticks
    tick_kind = 2;
    wr(1'b1, 8'hAC);
    idle(200);
    tick_kind = 0;
    wr(1'b1, 8'hAC);
    n = 0;
    for (int i = 0; i < 300; i++) begin @(negedge clk); if (nmi_req) n++; end
    chk("R10 no expiry without ticks", n, 0);
    tick_kind = 1;
    idle(10);

    // R6 halted mode
    do_reset();
    wr(1'b0, 8'h07);
    wr(1'b1, 8'h11);
    chk("R6 wrong key ignored when halted", {nmi_req, wdt_rst}, 0);
    wr(1'b0, 8'h40);
    chk("R6 mode rewrite ignored when halted", {nmi_req, wdt_rst}, 0);
    bus_addr = 1'b0;
    #1 chk("R2 halted mode value kept", bus_rdata, 8'h07);
    n = 0;
    for (int i = 0; i < 3000; i++) begin @(negedge clk); if (nmi_req || wdt_rst) n++; end
    chk("R6 halted counter never expires", n, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule